// File: doc/BRIEF.md
# Backlight PWM Generator with Staged Configuration

This block drives one display-backlight pulse-width output from a small register interface. Software programs an enable bit, a clock prescaler, a period count and a high-time count. Prescaler, period and high-time writes land in shadow registers first. An explicit commit strobe copies them into a staging set. The staging set then moves into the working registers at the next period boundary, so a running waveform never shows a truncated or mixed period.

A two-bit direct-mode field switches the buffering off. While it is set, the working registers follow the shadow registers on every cycle and no commit is needed. Reads always return the shadow contents, so software sees what it last wrote even before any commit.

The waveform has normal polarity. The prescaler divides the input clock by (prescale+1). The period counter then runs through (period+1) prescaled steps. The output is high while the period count is below the high-time count.

Top module: `bl_pwm_top`

## Requirements
- R1: After reset, `pwm_out` is low and every register reads back as zero.
- R2: A read returns the shadow contents in this layout. Address 0 holds enable in bit 0. Address 1 holds prescale in bits [9:0]. Address 2 holds period in bits [11:0] and high time in bits [28:16]. Address 3 holds the commit bit in bit 0 and the direct-mode field in bits [5:4]. All other bits read as zero.
- R3: In buffered mode (direct field not 2'b11), writes to prescale, period or high time do not change the waveform until a commit.
- R4: A commit is a write of 1 to address 3 bit 0 followed by a write of 0 to it. The falling write stages the shadow values. Once applied, the waveform uses them.
- R5: One period lasts (prescale+1)*(period+1) clock cycles.
- R6: The output is high for the first (prescale+1)*high cycles of each period.
- R7: With high time 0 the output stays low. With high time greater than period+1 the output stays high.
- R8: Writing 0 to the enable bit drives `pwm_out` low from the clock edge that takes the write. While disabled, a pending commit applies on the next cycle.
- R9: With the direct field at 2'b11, shadow writes reach the working registers on the next cycle without a commit.
- R10: A commit issued mid-period lets the current period finish with the old values. The new values start at the following period boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 32 | Read data, combinational from shadow registers |
| pwm_out | output | 1 | Backlight PWM output |

## Verification
The embedded assertions check the following on every cycle:
- the output is low whenever the block is disabled or the high time is zero;
- the working values stay frozen unless a commit is pending or direct mode is on;
- a commit always leaves a pending transfer;
- the counters wrap to zero right after each period end.

Only the bench scenarios can show the measured period and high-time lengths for several prescaler settings. They also show that a mid-period commit completes the old period first, that the saturating high-time cases hold their level, and that direct mode takes effect without a commit.

// File: rtl/bl_pwm_pkg.sv
package bl_pwm_pkg;
  typedef enum logic [1:0] {
    REG_ENA  = 2'd0,
    REG_DIV  = 2'd1,
    REG_WAVE = 2'd2,
    REG_XFER = 2'd3
  } reg_sel_e;

  localparam int DATA_W_DEF = 32;
  localparam int DIV_W_DEF  = 10;
  localparam int PER_W_DEF  = 12;
  localparam int HW_W_DEF   = 13;
endpackage

// File: rtl/bl_pwm_regs.sv
module bl_pwm_regs
  import bl_pwm_pkg::*;
#(
  parameter int DATA_W = DATA_W_DEF,
  parameter int DIV_W  = DIV_W_DEF,
  parameter int PER_W  = PER_W_DEF,
  parameter int HW_W   = HW_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              period_end,
  output logic              enable,
  output logic [DIV_W-1:0]  work_div,
  output logic [PER_W-1:0]  work_per,
  output logic [HW_W-1:0]   work_hw
);
  localparam int HW_LSB  = 16;
  localparam int DBG_LSB = 4;
  localparam int DBG_W   = 2;

  logic [DIV_W-1:0] sh_div, st_div;
  logic [PER_W-1:0] sh_per, st_per;
  logic [HW_W-1:0]  sh_hw,  st_hw;
  logic             commit_q;
  logic [DBG_W-1:0] dbg_q;
  logic             pend;

  logic sel_ena, sel_div, sel_wave, sel_xfer;
  logic direct, commit_pulse, apply_now;

  assign sel_ena  = wr_en && (wr_addr == REG_ENA);
  assign sel_div  = wr_en && (wr_addr == REG_DIV);
  assign sel_wave = wr_en && (wr_addr == REG_WAVE);
  assign sel_xfer = wr_en && (wr_addr == REG_XFER);

  assign direct       = &dbg_q;
  assign commit_pulse = sel_xfer && commit_q && !wr_data[0] && !direct;
  assign apply_now    = pend && (!enable || period_end);

  // shadow registers, written by software
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable   <= 1'b0;
      sh_div   <= '0;
      sh_per   <= '0;
      sh_hw    <= '0;
      commit_q <= 1'b0;
      dbg_q    <= '0;
    end else begin
      if (sel_ena)  enable <= wr_data[0];
      if (sel_div)  sh_div <= wr_data[DIV_W-1:0];
      if (sel_wave) begin
        sh_per <= wr_data[PER_W-1:0];
        sh_hw  <= wr_data[HW_LSB +: HW_W];
      end
      if (sel_xfer) begin
        commit_q <= wr_data[0];
        dbg_q    <= wr_data[DBG_LSB +: DBG_W];
      end
    end
  end

  // staging set, loaded by the commit strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_div <= '0;
      st_per <= '0;
      st_hw  <= '0;
      pend   <= 1'b0;
    end else if (commit_pulse) begin
      st_div <= sh_div;
      st_per <= sh_per;
      st_hw  <= sh_hw;
      pend   <= 1'b1;
    end else if (direct || apply_now) begin
      pend   <= 1'b0;
    end
  end

  // working set, used by the counters
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      work_div <= '0;
      work_per <= '0;
      work_hw  <= '0;
    end else if (direct) begin
      work_div <= sh_div;
      work_per <= sh_per;
      work_hw  <= sh_hw;
    end else if (apply_now) begin
      work_div <= st_div;
      work_per <= st_per;
      work_hw  <= st_hw;
    end
  end

  always_comb begin
    rd_data = '0;
    case (reg_sel_e'(rd_addr))
      REG_ENA:  rd_data[0] = enable;
      REG_DIV:  rd_data[DIV_W-1:0] = sh_div;
      REG_WAVE: begin
        rd_data[PER_W-1:0]        = sh_per;
        rd_data[HW_LSB +: HW_W]   = sh_hw;
      end
      default: begin
        rd_data[0]                = commit_q;
        rd_data[DBG_LSB +: DBG_W] = dbg_q;
      end
    endcase
  end

  AST_HOLD_WORK: assert property (@(posedge clk) disable iff (!rst_n)
    (!direct && !pend) |=> ($stable(work_div) && $stable(work_per) && $stable(work_hw))) // R3
    else $error("working values changed without a commit");

  AST_COMMIT_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
    commit_pulse |=> pend) // R4
    else $error("commit left nothing pending");

  AST_DIRECT_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    direct |=> (work_per == $past(sh_per) && work_hw == $past(sh_hw))) // R9
    else $error("direct mode did not pass shadow through");
endmodule

// File: rtl/bl_pwm_counter.sv
module bl_pwm_counter
  import bl_pwm_pkg::*;
#(
  parameter int DIV_W = DIV_W_DEF,
  parameter int PER_W = PER_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  input  logic [PER_W-1:0] per,
  output logic [PER_W-1:0] pcnt,
  output logic             period_end
);
  logic [DIV_W-1:0] presc;
  logic             step;

  assign step       = (presc >= div);
  assign period_end = run && step && (pcnt >= per);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc <= '0;
      pcnt  <= '0;
    end else if (!run) begin
      presc <= '0;
      pcnt  <= '0;
    end else if (step) begin
      presc <= '0;
      pcnt  <= (pcnt >= per) ? '0 : pcnt + 1'b1;
    end else begin
      presc <= presc + 1'b1;
    end
  end

  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |=> (presc == '0 && pcnt == '0)) // R5
    else $error("counters did not restart after period end");
endmodule

// File: rtl/bl_pwm_top.sv
module bl_pwm_top
  import bl_pwm_pkg::*;
#(
  parameter int DATA_W = DATA_W_DEF,
  parameter int DIV_W  = DIV_W_DEF,
  parameter int PER_W  = PER_W_DEF,
  parameter int HW_W   = HW_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              pwm_out
);
  localparam int CMP_W = (PER_W > HW_W) ? PER_W + 1 : HW_W + 1;

  logic             enable;
  logic [DIV_W-1:0] work_div;
  logic [PER_W-1:0] work_per;
  logic [HW_W-1:0]  work_hw;
  logic [PER_W-1:0] pcnt;
  logic             period_end;

  bl_pwm_regs #(
    .DATA_W(DATA_W), .DIV_W(DIV_W), .PER_W(PER_W), .HW_W(HW_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .period_end(period_end), .enable(enable),
    .work_div(work_div), .work_per(work_per), .work_hw(work_hw)
  );

  bl_pwm_counter #(
    .DIV_W(DIV_W), .PER_W(PER_W)
  ) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(enable),
    .div(work_div), .per(work_per),
    .pcnt(pcnt), .period_end(period_end)
  );

  assign pwm_out = enable && (CMP_W'(pcnt) < CMP_W'(work_hw));

  AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !pwm_out) // R8
    else $error("output high while disabled");

  AST_ZERO_HW_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (work_hw == '0) |-> !pwm_out) // R7
    else $error("output high with zero high time");
endmodule

// File: tb/sim_bl_pwm_top.sv
`timescale 1ns/1ps
module sim_bl_pwm_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        pwm_out;

  int errors = 0;
  int checks = 0;

  int    q_hi[$];
  int    q_per[$];
  string q_tag[$];
  bit    have_rise = 0;
  bit    prev_pwm = 0;
  int    cnt_hi = 0;
  int    cnt_per = 0;

  always #2 clk = ~clk;

  bl_pwm_top u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .pwm_out(pwm_out)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic commit();
    wr(2'd3, 32'h1);
    wr(2'd3, 32'h0);
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [31:0] exp, input string tag);
    rd_addr = a; #1;
    check(rd_data == exp, tag, int'(rd_data), int'(exp));
  endtask

  task automatic level_chk(input bit lvl, input int n, input string tag);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_out != lvl) bad++;
    end
    check(bad == 0, tag, bad, 0);
  endtask

  // driver side of the scoreboard
  task automatic expect_wave(input int hi, input int per, input string tag);
    q_hi.push_back(hi); q_per.push_back(per); q_tag.push_back(tag);
  endtask

  task automatic arm();
    @(posedge clk); #1;
    have_rise = 0;
  endtask

  task automatic drain(input string tag);
    int t = 0;
    while (q_hi.size() > 0 && t < 3000) begin
      @(posedge clk); t++;
    end
    if (q_hi.size() > 0) begin
      check(0, tag, q_hi.size(), 0);
      q_hi.delete(); q_per.delete(); q_tag.delete();
    end
  endtask

  // monitor side: measures each complete period between rising edges
  always @(negedge clk) begin
    if (pwm_out && !prev_pwm) begin
      if (have_rise && q_hi.size() > 0) begin
        int eh, ep; string tg;
        eh = q_hi.pop_front(); ep = q_per.pop_front(); tg = q_tag.pop_front();
        check(cnt_per == ep, {tg, " period"}, cnt_per, ep);
        check(cnt_hi == eh, {tg, " high"}, cnt_hi, eh);
      end
      have_rise = 1;
      cnt_per = 0;
      cnt_hi = 0;
    end
    cnt_per++;
    if (pwm_out) cnt_hi++;
    prev_pwm = pwm_out;
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(pwm_out == 1'b0, "R1 pwm low", int'(pwm_out), 0);
    rd_chk(2'd0, 32'h0, "R1 ena");
    rd_chk(2'd1, 32'h0, "R1 div");
    rd_chk(2'd2, 32'h0, "R1 wave");
    rd_chk(2'd3, 32'h0, "R1 xfer");

    // R2 shadow readback before any commit
    wr(2'd1, 32'h1);
    wr(2'd2, (32'd4 << 16) | 32'd9);
    rd_chk(2'd1, 32'h1, "R2 div");
    rd_chk(2'd2, 32'h0004_0009, "R2 wave");
    wr(2'd0, 32'h1);
    rd_chk(2'd0, 32'h1, "R2 ena");
    // R3 nothing visible until commit
    level_chk(1'b0, 50, "R3 no commit yet");

    // R4 R5 R6 commit then measure div=1 per=9 hw=4
    commit();
    arm();
    expect_wave(8, 20, "R5 R6 wave A");
    expect_wave(8, 20, "R4 wave A repeat");
    drain("R4 timeout A");

    // R3 shadow change without commit keeps waveform
    wr(2'd1, 32'h0);
    wr(2'd2, (32'd2 << 16) | 32'd4);
    arm();
    expect_wave(8, 20, "R3 unchanged");
    drain("R3 timeout");

    // R10 commit mid-period: old period completes, then new
    arm();
    expect_wave(8, 20, "R10 old period");
    expect_wave(2, 5, "R10 new period");
    @(posedge pwm_out);
    repeat (3) @(posedge clk);
    commit();
    drain("R10 timeout");

    // R7 zero high time
    wr(2'd2, 32'd4);
    commit();
    repeat (12) @(posedge clk);
    level_chk(1'b0, 40, "R7 zero high");
    // R7 high time beyond period
    wr(2'd2, (32'd13 << 16) | 32'd4);
    commit();
    repeat (12) @(posedge clk);
    level_chk(1'b1, 40, "R7 saturate high");

    // R8 disable drops output at once
    wr(2'd0, 32'h0);
    check(pwm_out == 1'b0, "R8 disable", int'(pwm_out), 0);
    level_chk(1'b0, 10, "R8 stays low");

    // R9 direct mode, no commit
    wr(2'd3, 32'h30);
    rd_chk(2'd3, 32'h30, "R9 xfer readback");
    wr(2'd0, 32'h1);
    wr(2'd2, (32'd3 << 16) | 32'd7);
    arm();
    expect_wave(3, 8, "R9 direct wave");
    expect_wave(3, 8, "R9 direct repeat");
    drain("R9 timeout");

    summary();
  end
endmodule